// File: doc/BRIEF.md
# Display Channel Status and Interrupt Collector

This block gathers progress and error conditions from three display output channels and one memory-read master, records them in sticky status bits, and turns them into interrupt lines. Every channel supplies single-cycle strobes (line start, frame start, a downstream read of its output FIFO, end of the programmed line, output buffer low) together with two levels: whether pixels of the current output line are still pending and whether the FIFO is empty. It also supplies a 2-bit operating mode. The memory master reports a 2-bit response code with a valid strobe, plus a strobe for a transaction carrying an invalid ID. A profiler event strobe is the last source.

Software reaches two 32-bit registers through a small synchronous port: a control register at address 0 and a status register at address 1. Read data is registered and appears one cycle after the address. Interrupt outputs are registered as well. One master enable gates every interrupt output, but it never stops the status bits from recording events.

Top module: `dsi_irq_unit`

## Requirements
- R1: After synchronous reset the control register, every status bit, the read data and all interrupt outputs are zero.
- R2: Channel mode encoding is 0 off, 1 init, 2 run, 3 end-of-frame. The end-of-frame status bit (channel field offset 0) sets only when the mode moves from 2 to 3 between consecutive cycles. A move from 1 to 3 leaves it clear.
- R3: A line-start strobe while pixels are pending sets the short-line bit (offset 2). A frame-start strobe while pixels are pending sets the short-frame bit (offset 3). Without pending pixels neither strobe has any effect.
- R4: A FIFO read while the FIFO is empty sets the underflow bit (offset 1). A read while not empty has no effect.
- R5: The end-of-line strobe sets offset 4 and the buffer-low strobe sets offset 5. The field of channel c starts at status bit 8+8c.
- R6: Status bit 1+c is channel c pending. It equals (end-of-frame AND control bit 8+4c) OR (end-of-line AND control bit 9+4c) OR ((short-line OR underflow) AND control bit 10+4c) OR short-frame. Short-frame needs no enable, and buffer-low never contributes.
- R7: Status bit 4 (memory error pending) sets on an invalid-ID strobe or on a valid response other than 0 (codes: 0 okay, 1 exclusive okay, 2 slave error, 3 decode error). Bit 7 sets on an invalid-ID strobe. Bits 15:14 hold the code of the latest valid response.
- R8: Writing 1 to status bits 4, 7 or any channel field bit clears that bit. Writing 0 has no effect. Writing 1 to bit 0 clears every status bit, including bit 0 and bits 15:14.
- R9: An event that sets a status bit in the same cycle as a write that clears it leaves the bit set.
- R10: Status bit 0 records the profiler event strobe and is cleared only by the clear-all write.
- R11: The outputs are registered and follow the state one cycle later. irq_chan_o[c] = master AND control bit 1+c AND pending c. irq_dma_o = master AND control bit 4 AND status bit 4. irq_prof_o = master AND control bit 0 AND status bit 0. irq_any_o is the OR of these three.
- R12: With master enable (control bit 31) low, all interrupt outputs stay low while status bits keep recording.
- R13: reg_rdata_o shows the register selected by reg_addr_i in the previous cycle, as it stood before that cycle's clock edge. Unused control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | NUM_CH | Line start strobe per channel |
| frame_start_i | input | NUM_CH | Frame start strobe per channel |
| pix_pend_i | input | NUM_CH | Pixels of the current output line still pending |
| fifo_rd_i | input | NUM_CH | Downstream read of the channel output FIFO |
| fifo_empty_i | input | NUM_CH | Channel output FIFO empty |
| mode_i | input | 2*NUM_CH | Channel mode, 2 bits per channel |
| eoln_i | input | NUM_CH | Programmed line finished strobe |
| buf_low_i | input | NUM_CH | Output buffer low strobe |
| dma_resp_valid_i | input | 1 | Memory response valid |
| dma_resp_i | input | 2 | Memory response code |
| dma_bad_id_i | input | 1 | Invalid transaction ID strobe |
| prof_evt_i | input | 1 | Profiler event strobe |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 1 | 0 control, 1 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_chan_o | output | NUM_CH | Per-channel interrupt |
| irq_dma_o | output | 1 | Memory error interrupt |
| irq_prof_o | output | 1 | Profiler interrupt |
| irq_any_o | output | 1 | OR of all interrupts |

## Verification
A new event and a software clear of the same status bit can fall in the same clock cycle, and so can an event and the clear-all write. Directed cases drive a short-line condition on a channel in the same cycle as a write-one-to-clear of that bit, and a profiler event or memory response in the same cycle as the clear-all write. The random phase issues status writes with random masks while strobes fire, so such collisions happen often. A cycle-by-cycle model gives the expected register contents, and the read data of the following cycle must show the bit still set.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int EV_W = 6;
  // offsets inside one channel status field
  localparam int EV_EOF  = 0;
  localparam int EV_UFL  = 1;
  localparam int EV_SLN  = 2;
  localparam int EV_SFR  = 3;
  localparam int EV_EOLN = 4;
  localparam int EV_BLOW = 5;

  localparam logic [1:0] MODE_RUN = 2'd2;
  localparam logic [1:0] MODE_EOF = 2'd3;
  localparam logic [1:0] RESP_OK  = 2'd0;

  // status register layout
  localparam int ST_PROF   = 0;
  localparam int ST_CH0    = 1;
  localparam int ST_DMA    = 4;
  localparam int ST_BADID  = 7;
  localparam int ST_FLD0   = 8;
  localparam int ST_FLD_ST = 8;
  localparam int ST_CODE   = 14;

  // control register layout
  localparam int CT_PROF   = 0;
  localparam int CT_CH0    = 1;
  localparam int CT_DMA    = 4;
  localparam int CT_SRC0   = 8;
  localparam int CT_SRC_ST = 4;
  localparam int CT_MASTER = 31;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  function automatic logic [31:0] ctrl_mask(int n);
    logic [31:0] m;
    m = 32'h0000_001F;
    m[CT_MASTER] = 1'b1;
    for (int c = 0; c < n; c++) m[CT_SRC0 + CT_SRC_ST*c +: 3] = 3'b111;
    return m;
  endfunction
endpackage

// File: rtl/dsi_chan_status.sv
module dsi_chan_status
  import dsi_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            line_start_i,
  input  logic            frame_start_i,
  input  logic            pix_pend_i,
  input  logic            fifo_rd_i,
  input  logic            fifo_empty_i,
  input  logic [1:0]      mode_i,
  input  logic            eoln_i,
  input  logic            buf_low_i,
  input  logic [EV_W-1:0] clr_i,
  output logic [EV_W-1:0] st_o
);
  logic [1:0]      mode_q;
  logic [EV_W-1:0] set_w;
  logic [EV_W-1:0] st_q;

  always_comb begin
    set_w          = '0;
    set_w[EV_EOF]  = (mode_q == MODE_RUN) && (mode_i == MODE_EOF);
    set_w[EV_UFL]  = fifo_rd_i && fifo_empty_i;
    set_w[EV_SLN]  = line_start_i && pix_pend_i;
    set_w[EV_SFR]  = frame_start_i && pix_pend_i;
    set_w[EV_EOLN] = eoln_i;
    set_w[EV_BLOW] = buf_low_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      st_q   <= '0;
    end else begin
      mode_q <= mode_i;
      st_q   <= (st_q & ~clr_i) | set_w;
    end
  end

  assign st_o = st_q;

  // R2
  eof_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q[EV_EOF]) |-> ($past(mode_i) == MODE_EOF) && ($past(mode_q) == MODE_RUN));

  for (genvar b = 0; b < EV_W; b++) begin : g_bit_chk
    // R8
    fall_needs_clr_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(st_q[b]) |-> $past(clr_i[b]));
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      $past(set_w[b] && !rst) |-> st_q[b]);
  end
endmodule

// File: rtl/dsi_dma_status.sv
module dsi_dma_status
  import dsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       resp_valid_i,
  input  logic [1:0] resp_i,
  input  logic       bad_id_i,
  input  logic       clr_pend_i,
  input  logic       clr_badid_i,
  input  logic       clr_all_i,
  output logic       pend_o,
  output logic       badid_o,
  output logic [1:0] code_o
);
  logic       pend_q, badid_q;
  logic [1:0] code_q;
  logic       err_w;

  assign err_w = bad_id_i || (resp_valid_i && (resp_i != RESP_OK));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      badid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      pend_q  <= (pend_q  && !clr_pend_i)  || err_w;
      badid_q <= (badid_q && !clr_badid_i) || bad_id_i;
      if (resp_valid_i)   code_q <= resp_i;
      else if (clr_all_i) code_q <= '0;
    end
  end

  assign pend_o  = pend_q;
  assign badid_o = badid_q;
  assign code_o  = code_q;

  // R7
  bad_id_sets_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bad_id_i && !rst) |-> pend_q && badid_q);
  // R7
  okay_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(bad_id_i) || ($past(resp_valid_i) && $past(resp_i) != RESP_OK));
endmodule

// File: rtl/dsi_irq_unit.sv
module dsi_irq_unit
  import dsi_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   line_start_i,
  input  logic [NUM_CH-1:0]   frame_start_i,
  input  logic [NUM_CH-1:0]   pix_pend_i,
  input  logic [NUM_CH-1:0]   fifo_rd_i,
  input  logic [NUM_CH-1:0]   fifo_empty_i,
  input  logic [2*NUM_CH-1:0] mode_i,
  input  logic [NUM_CH-1:0]   eoln_i,
  input  logic [NUM_CH-1:0]   buf_low_i,
  input  logic                dma_resp_valid_i,
  input  logic [1:0]          dma_resp_i,
  input  logic                dma_bad_id_i,
  input  logic                prof_evt_i,
  input  logic                reg_wr_i,
  input  logic                reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic [NUM_CH-1:0]   irq_chan_o,
  output logic                irq_dma_o,
  output logic                irq_prof_o,
  output logic                irq_any_o
);
  localparam logic [31:0] CTRL_MASK = ctrl_mask(NUM_CH);

  logic [31:0]     ctrl_q;
  logic            prof_q;
  logic            wr_ctrl, wr_stat, clr_all;
  logic [EV_W-1:0] ch_st  [NUM_CH];
  logic [EV_W-1:0] ch_clr [NUM_CH];
  logic [NUM_CH-1:0] ch_pend;
  logic            dma_pend, dma_badid;
  logic [1:0]      dma_code;
  logic [31:0]     status_w;
  logic [NUM_CH-1:0] chan_gate;
  logic            dma_gate, prof_gate;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_STAT);
  assign clr_all = wr_stat && reg_wdata_i[ST_PROF];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_clr[g] = !wr_stat ? '0 :
                       clr_all  ? '1 : reg_wdata_i[ST_FLD0 + ST_FLD_ST*g +: EV_W];

    dsi_chan_status u_ch (
      .clk          (clk),
      .rst          (rst),
      .line_start_i (line_start_i[g]),
      .frame_start_i(frame_start_i[g]),
      .pix_pend_i   (pix_pend_i[g]),
      .fifo_rd_i    (fifo_rd_i[g]),
      .fifo_empty_i (fifo_empty_i[g]),
      .mode_i       (mode_i[2*g +: 2]),
      .eoln_i       (eoln_i[g]),
      .buf_low_i    (buf_low_i[g]),
      .clr_i        (ch_clr[g]),
      .st_o         (ch_st[g])
    );

    assign ch_pend[g] = (ch_st[g][EV_EOF]  && ctrl_q[CT_SRC0 + CT_SRC_ST*g])
                     || (ch_st[g][EV_EOLN] && ctrl_q[CT_SRC0 + CT_SRC_ST*g + 1])
                     || ((ch_st[g][EV_SLN] || ch_st[g][EV_UFL]) && ctrl_q[CT_SRC0 + CT_SRC_ST*g + 2])
                     || ch_st[g][EV_SFR];
    assign chan_gate[g] = ctrl_q[CT_CH0 + g] && ch_pend[g];
  end

  dsi_dma_status u_dma (
    .clk         (clk),
    .rst         (rst),
    .resp_valid_i(dma_resp_valid_i),
    .resp_i      (dma_resp_i),
    .bad_id_i    (dma_bad_id_i),
    .clr_pend_i  (wr_stat && (reg_wdata_i[ST_DMA] || clr_all)),
    .clr_badid_i (wr_stat && (reg_wdata_i[ST_BADID] || clr_all)),
    .clr_all_i   (clr_all),
    .pend_o      (dma_pend),
    .badid_o     (dma_badid),
    .code_o      (dma_code)
  );

  assign dma_gate  = ctrl_q[CT_DMA]  && dma_pend;
  assign prof_gate = ctrl_q[CT_PROF] && prof_q;

  always_comb begin
    status_w = '0;
    status_w[ST_PROF]  = prof_q;
    status_w[ST_DMA]   = dma_pend;
    status_w[ST_BADID] = dma_badid;
    status_w[ST_CODE +: 2] = dma_code;
    for (int c = 0; c < NUM_CH; c++) begin
      status_w[ST_CH0 + c] = ch_pend[c];
      status_w[ST_FLD0 + ST_FLD_ST*c +: EV_W] = ch_st[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      prof_q      <= 1'b0;
      reg_rdata_o <= '0;
      irq_chan_o  <= '0;
      irq_dma_o   <= 1'b0;
      irq_prof_o  <= 1'b0;
      irq_any_o   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i & CTRL_MASK;
      prof_q      <= (prof_q && !clr_all) || prof_evt_i;
      reg_rdata_o <= (reg_addr_i == ADDR_STAT) ? status_w : ctrl_q;
      irq_chan_o  <= ctrl_q[CT_MASTER] ? chan_gate : '0;
      irq_dma_o   <= ctrl_q[CT_MASTER] && dma_gate;
      irq_prof_o  <= ctrl_q[CT_MASTER] && prof_gate;
      irq_any_o   <= ctrl_q[CT_MASTER] && (|chan_gate || dma_gate || prof_gate);
    end
  end

  // R12
  master_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any_o |-> $past(ctrl_q[CT_MASTER]));
  // R10
  prof_record_chk: assert property (@(posedge clk) disable iff (rst)
    $past(prof_evt_i && !rst) |-> prof_q);
  // R11
  any_is_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any_o == (|irq_chan_o || irq_dma_o || irq_prof_o));
endmodule

// File: tb/dsi_irq_unit_tb.sv
module dsi_irq_unit_tb;
  localparam int N = 3;
  localparam logic [31:0] CMASK = 32'h8007_771F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [N-1:0] ls, fs, pp, frd, femp, eo, bl;
  logic [2*N-1:0] mode;
  logic rv, bad, prof, wr, addr;
  logic [1:0] resp;
  logic [31:0] wd;
  logic [31:0] rdata;
  logic [N-1:0] irq_ch;
  logic irq_dma, irq_prof, irq_any;

  dsi_irq_unit #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst(rst), .line_start_i(ls), .frame_start_i(fs), .pix_pend_i(pp),
    .fifo_rd_i(frd), .fifo_empty_i(femp), .mode_i(mode), .eoln_i(eo), .buf_low_i(bl),
    .dma_resp_valid_i(rv), .dma_resp_i(resp), .dma_bad_id_i(bad), .prof_evt_i(prof),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .irq_chan_o(irq_ch), .irq_dma_o(irq_dma), .irq_prof_o(irq_prof), .irq_any_o(irq_any));

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the register state
  logic [31:0] m_ctrl;
  logic [5:0]  m_ch [N];
  logic [1:0]  m_mq [N];
  logic m_prof, m_pend, m_badid;
  logic [1:0] m_code;

  function automatic logic m_chpend(int c);
    return (m_ch[c][0] & m_ctrl[8+4*c]) | (m_ch[c][4] & m_ctrl[9+4*c]) |
           ((m_ch[c][2] | m_ch[c][1]) & m_ctrl[10+4*c]) | m_ch[c][3];
  endfunction

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    s[0] = m_prof; s[4] = m_pend; s[7] = m_badid; s[15:14] = m_code;
    for (int c = 0; c < N; c++) begin
      s[1+c] = m_chpend(c);
      s[8+8*c +: 6] = m_ch[c];
    end
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic ca, st;
    logic [5:0] set, clr;
    st = wr && addr;
    ca = st && wd[0];
    for (int c = 0; c < N; c++) begin
      set[0] = (m_mq[c] == 2'd2) && (mode[2*c +: 2] == 2'd3);
      set[1] = frd[c] & femp[c];
      set[2] = ls[c] & pp[c];
      set[3] = fs[c] & pp[c];
      set[4] = eo[c];
      set[5] = bl[c];
      clr = !st ? 6'h0 : ca ? 6'h3F : wd[8+8*c +: 6];
      m_ch[c] = (m_ch[c] & ~clr) | set;
      m_mq[c] = mode[2*c +: 2];
    end
    m_pend  = (m_pend  & ~(st & (wd[4] | ca))) | bad | (rv & (resp != 2'd0));
    m_badid = (m_badid & ~(st & (wd[7] | ca))) | bad;
    if (rv) m_code = resp; else if (ca) m_code = 2'd0;
    m_prof = (m_prof & ~ca) | prof;
    if (wr && !addr) m_ctrl = wd & CMASK;
  endtask

  // one clock: predict, advance, compare read data and interrupts
  task automatic step();
    logic [31:0] exp_rd;
    logic [N-1:0] ec;
    logic ed, ep, ea, ms;
    exp_rd = addr ? m_status() : m_ctrl;
    ms = m_ctrl[31];
    for (int c = 0; c < N; c++) ec[c] = ms & m_ctrl[1+c] & m_chpend(c);
    ed = ms & m_ctrl[4] & m_pend;
    ep = ms & m_ctrl[0] & m_prof;
    ea = |ec | ed | ep;
    model_update();
    @(posedge clk); #1;
    chk("R13 read data", rdata, exp_rd);
    chk("R11 interrupt outputs", {26'd0, ea, ep, ed, ec}, {26'd0, irq_any, irq_prof, irq_dma, irq_ch});
  endtask

  task automatic idle();
    ls = '0; fs = '0; frd = '0; eo = '0; bl = '0;
    rv = 0; bad = 0; prof = 0; wr = 0; wd = '0;
  endtask

  task automatic read_stat();
    idle(); addr = 1; step();
  endtask

  task automatic wreg(logic a, logic [31:0] d);
    idle(); wr = 1; addr = a; wd = d; step(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); pp = '0; femp = '0; mode = '0; resp = '0; addr = 0;
    m_ctrl = '0; m_prof = 0; m_pend = 0; m_badid = 0; m_code = '0;
    for (int c = 0; c < N; c++) begin m_ch[c] = '0; m_mq[c] = '0; end
    repeat (4) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    addr = 0; step(); chk("R1 control after reset", rdata, 32'h0);
    read_stat(); chk("R1 status after reset", rdata, 32'h0);
    chk("R1 irq after reset", {28'd0, irq_any, irq_prof, irq_dma, irq_ch}, 32'h0);

    // R2 end-of-frame only from run
    mode[1:0] = 2'd1; read_stat(); mode[1:0] = 2'd3; read_stat();
    read_stat(); chk("R2 init->eof no set", {31'd0, rdata[8]}, 32'd0);
    mode[1:0] = 2'd2; read_stat(); mode[1:0] = 2'd3; read_stat();
    read_stat(); chk("R2 run->eof sets", {31'd0, rdata[8]}, 32'd1);
    mode[1:0] = 2'd0;

    // R3 short line / short frame on channel 1
    idle(); ls[1] = 1; pp[1] = 0; addr = 1; step();
    read_stat(); chk("R3 line start no pending", {31'd0, rdata[18]}, 32'd0);
    idle(); ls[1] = 1; pp[1] = 1; step();
    read_stat(); chk("R3 short line", {31'd0, rdata[18]}, 32'd1);
    idle(); fs[1] = 1; step(); pp[1] = 0;
    read_stat(); chk("R3 short frame", {31'd0, rdata[19]}, 32'd1);

    // R4 underflow on channel 2
    idle(); frd[2] = 1; femp[2] = 0; step();
    read_stat(); chk("R4 read not empty", {31'd0, rdata[25]}, 32'd0);
    idle(); frd[2] = 1; femp[2] = 1; step(); femp[2] = 0;
    read_stat(); chk("R4 underflow", {31'd0, rdata[25]}, 32'd1);

    // R5 end-of-line and buffer low on channel 0
    idle(); eo[0] = 1; step(); idle(); bl[0] = 1; step();
    read_stat(); chk("R5 eoln and buffer low", {30'd0, rdata[13:12]}, 32'd3);

    // R6 pending: short frame needs no enable
    read_stat(); chk("R6 pending with enables off", {29'd0, rdata[3:1]}, 32'b010);
    wreg(0, 32'h0004_0000);
    read_stat(); chk("R6 slur enable ch2", {29'd0, rdata[3:1]}, 32'b110);

    // R8 write one to clear, write zero ignored
    wreg(1, 32'h0008_0000);
    read_stat(); chk("R8 w1c short frame", {30'd0, rdata[19:18]}, 32'b01);
    wreg(1, 32'h0);
    read_stat(); chk("R8 write zero ignored", {31'd0, rdata[18]}, 32'd1);

    // R9 event and clear in the same cycle
    idle(); ls[1] = 1; pp[1] = 1; wr = 1; addr = 1; wd = 32'h0004_0000; step(); pp[1] = 0;
    read_stat(); chk("R9 set beats clear", {31'd0, rdata[18]}, 32'd1);

    // R7 memory responses
    idle(); rv = 1; resp = 2'd0; step();
    read_stat(); chk("R7 okay no error", {31'd0, rdata[4]}, 32'd0);
    idle(); rv = 1; resp = 2'd2; step();
    read_stat(); chk("R7 slave error", {29'd0, rdata[15:14], rdata[4]}, 32'b101);
    idle(); bad = 1; step();
    read_stat(); chk("R7 invalid id", {31'd0, rdata[7]}, 32'd1);

    // R12 master gate
    wreg(0, 32'h0000_0102);
    mode[1:0] = 2'd2; read_stat(); mode[1:0] = 2'd3; read_stat(); mode[1:0] = 2'd0;
    read_stat();
    chk("R12 status records with master off", {31'd0, rdata[1]}, 32'd1);
    chk("R12 irq gated", {31'd0, irq_ch[0]}, 32'd0);
    wreg(0, 32'h8000_0102); read_stat();
    chk("R11 irq after master on", {30'd0, irq_any, irq_ch[0]}, 32'b11);

    // R10 profiler and clear-all colliding with a new response
    idle(); prof = 1; step();
    read_stat(); chk("R10 profiler bit", {31'd0, rdata[0]}, 32'd1);
    wreg(1, 32'h0000_0001);
    read_stat(); chk("R8 clear all", rdata, 32'h0);
    idle(); prof = 1; wr = 1; addr = 1; wd = 32'h1; rv = 1; resp = 2'd3; step();
    read_stat(); chk("R9 events beat clear all", {29'd0, rdata[15:14], rdata[0]}, 32'b111);

    // random phase, fixed seed
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1500; i++) begin
      idle();
      for (int c = 0; c < N; c++) begin
        ls[c]  = ($urandom % 8) == 0;
        fs[c]  = ($urandom % 8) == 0;
        frd[c] = ($urandom % 6) == 0;
        eo[c]  = ($urandom % 8) == 0;
        bl[c]  = ($urandom % 10) == 0;
        pp[c]  = $urandom % 2;
        femp[c] = $urandom % 2;
        if (($urandom % 4) == 0) mode[2*c +: 2] = 2'($urandom);
      end
      rv = ($urandom % 6) == 0; resp = 2'($urandom);
      bad = ($urandom % 20) == 0;
      prof = ($urandom % 16) == 0;
      addr = $urandom % 2;
      if (($urandom % 6) == 0) begin
        wr = 1; wd = $urandom;
        if (addr && ($urandom % 8) != 0) wd[0] = 0;
      end
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule